// File: doc/BRIEF.md
# Expansion RAM DMA Controller

This block copies bytes between a host memory and a banked expansion RAM without processor involvement. Software sets it up through eleven byte-wide registers. These hold a host address, a 16-bit expansion address with a bank field, a byte count and control bytes. It then writes a command that selects one of four modes: copy host to expansion, copy expansion to host, exchange the two ranges, or compare them. The block drives one request/acknowledge port into each memory and performs one access at a time.

A command either starts at once or arms the engine. An armed engine starts when it sees a host write to a trigger address on a snoop input. At the end of a transfer the engine sets a completion flag and clears the execute bit. It can also restore the programmed addresses and count. The engine can hold each side's address fixed. It raises an interrupt when an enabled event occurs.

Top module: `rdma_top`

## Requirements
- R1: After reset, status reads `{3'b000, CHIP_TYPE, VERSION}` (0x10 by default), and all other registers read 0 and `irq_o` is low. Register offsets are: 0 status, 1 command, 2/3 host address low/high, 4/5 expansion address low/high, 6 bank, 7/8 length low/high, 9 interrupt control, 10 address control.
- R2: Mode 00 in command bits 1:0 (bit 7 = execute, bit 4 = start now) copies length bytes from host to expansion. Each address steps up by one per byte. The length counts down and reads 1 after a completed transfer that is not reloaded.
- R3: Mode 01 copies length bytes from expansion to host.
- R4: Mode 10 exchanges the two ranges byte by byte.
- R5: Mode 11 compares the ranges. When they match it sets only the end flag (status bit 6). A mismatch sets the error flag (status bit 5) and stops the transfer, with the addresses and length left at the failing byte.
- R6: When execute is set and start-now (bit 4) is clear, the engine issues no memory access until it sees a snoop write to address TRIG_ADDR (0xFF00). Snoop reads and writes to other addresses do not start it.
- R7: With command bit 5 set, the host address, expansion address and length return to their programmed values when the transfer ends.
- R8: The bank field is BANK_W (3) bits wide and reads with its upper bits at 0. The expansion address carries from 0xFFFF into the bank, and bank 7 wraps to bank 0.
- R9: Address control bit 7 holds the host address fixed, and bit 6 holds the expansion address fixed.
- R10: A length of 0 transfers 65536 bytes.
- R11: Completion sets the end flag and clears command bit 7. A status read returns the flags and then clears bits 7:5.
- R12: `irq_o` follows status bit 7. Bit 7 is set on completion when interrupt control bits 7 and 6 are set, or on a compare error when bits 7 and 5 are set.
- R13: Register writes made while a transfer runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_cs_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write (1) or read (0) |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| snoop_we_i | input | 1 | Host bus write seen |
| snoop_addr_i | input | 16 | Host bus address seen |
| h_req_o | output | 1 | Host memory request |
| h_we_o | output | 1 | Host memory write |
| h_addr_o | output | 16 | Host memory address |
| h_wdata_o | output | 8 | Host write data |
| h_rdata_i | input | 8 | Host read data, valid with ack |
| h_ack_i | input | 1 | Host access complete |
| x_req_o | output | 1 | Expansion memory request |
| x_we_o | output | 1 | Expansion memory write |
| x_addr_o | output | 16+BANK_W | Expansion address {bank, offset} |
| x_wdata_o | output | 8 | Expansion write data |
| x_rdata_i | input | 8 | Expansion read data, valid with ack |
| x_ack_i | input | 1 | Expansion access complete |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Transfer in progress |

## Verification
A wrong sequencer state shows up within one byte time. Data lands at the wrong place in either memory, or the final addresses and length read back differently. The wrong state also changes the count of host reads, which the 64 Ki-byte run checks. A fault in the flag or interrupt logic shows in the first status read after completion, and in `irq_o` one cycle after the final state. A trigger decode fault shows as a write to the expansion memory before the trigger, which the bench reads back directly.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    M_TO_EXP  = 2'd0,
    M_TO_HOST = 2'd1,
    M_SWAP    = 2'd2,
    M_CMP     = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_RD_H, S_RD_X, S_WR_H, S_WR_X, S_FIN
  } fsm_state_e;

  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h1;
  localparam logic [3:0] OFS_HLO  = 4'h2;
  localparam logic [3:0] OFS_HHI  = 4'h3;
  localparam logic [3:0] OFS_XLO  = 4'h4;
  localparam logic [3:0] OFS_XHI  = 4'h5;
  localparam logic [3:0] OFS_BANK = 4'h6;
  localparam logic [3:0] OFS_LLO  = 4'h7;
  localparam logic [3:0] OFS_LHI  = 4'h8;
  localparam logic [3:0] OFS_ICTL = 4'h9;
  localparam logic [3:0] OFS_ACTL = 4'hA;
endpackage

// File: rtl/rdma_ctr.sv
module rdma_ctr #(
  parameter int unsigned W    = 16,
  parameter bit          DOWN = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  input  logic         reload_i,
  input  logic         step_i,
  output logic [W-1:0] cur_o
);
  logic [W-1:0] prog_q, cur_q, nxt;

  generate
    if (DOWN) begin : g_down
      assign nxt = cur_q - W'(1);
    end else begin : g_up
      assign nxt = cur_q + W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= '0;
      cur_q  <= '0;
    end else if (wr_i) begin
      prog_q <= wr_val_i;
      cur_q  <= wr_val_i;
    end else if (reload_i) begin
      cur_q <= prog_q;
    end else if (step_i) begin
      cur_q <= nxt;
    end
  end

  assign cur_o = cur_q;

  a_r7_reload_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && !wr_i) |=> (cur_o == $past(prog_q)));
endmodule

// File: rtl/rdma_fsm.sv
module rdma_fsm import rdma_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic       exec_i,
  input  logic       imm_i,
  input  xfer_mode_e start_mode_i,
  input  xfer_mode_e mode_i,
  input  logic       trig_i,
  input  logic       last_i,
  input  logic       h_ack_i,
  input  logic [7:0] h_rdata_i,
  input  logic       x_ack_i,
  input  logic [7:0] x_rdata_i,
  output logic       h_req_o,
  output logic       h_we_o,
  output logic [7:0] h_wdata_o,
  output logic       x_req_o,
  output logic       x_we_o,
  output logic [7:0] x_wdata_o,
  output logic       step_o,
  output logic       len_step_o,
  output logic       fin_o,
  output logic       mismatch_o,
  output logic       busy_o
);
  fsm_state_e st_q, st_d;
  logic [7:0] hbyte_q, xbyte_q;
  logic       byte_done;

  function automatic fsm_state_e first_st(input xfer_mode_e m);
    return (m == M_TO_HOST) ? S_RD_X : S_RD_H;
  endfunction

  always_comb begin
    st_d       = st_q;
    byte_done  = 1'b0;
    h_req_o    = 1'b0;
    h_we_o     = 1'b0;
    x_req_o    = 1'b0;
    x_we_o     = 1'b0;
    fin_o      = 1'b0;
    mismatch_o = 1'b0;
    step_o     = 1'b0;
    len_step_o = 1'b0;
    case (st_q)
      S_IDLE, S_ARMED: begin
        if (cmd_wr_i) begin
          if (!exec_i)    st_d = S_IDLE;
          else if (imm_i) st_d = first_st(start_mode_i);
          else            st_d = S_ARMED;
        end else if (st_q == S_ARMED && trig_i) begin
          st_d = first_st(mode_i);
        end
      end
      S_RD_H: begin
        h_req_o = 1'b1;
        if (h_ack_i) st_d = (mode_i == M_TO_EXP) ? S_WR_X : S_RD_X;
      end
      S_RD_X: begin
        x_req_o = 1'b1;
        if (x_ack_i) begin
          if (mode_i == M_CMP) begin
            if (x_rdata_i != hbyte_q) begin
              mismatch_o = 1'b1;
              st_d       = S_FIN;
            end else begin
              byte_done = 1'b1;
            end
          end else begin
            st_d = S_WR_H;
          end
        end
      end
      S_WR_H: begin
        h_req_o = 1'b1;
        h_we_o  = 1'b1;
        if (h_ack_i) begin
          if (mode_i == M_SWAP) st_d = S_WR_X;
          else                  byte_done = 1'b1;
        end
      end
      S_WR_X: begin
        x_req_o = 1'b1;
        x_we_o  = 1'b1;
        if (x_ack_i) byte_done = 1'b1;
      end
      S_FIN: begin
        fin_o = 1'b1;
        st_d  = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (byte_done) begin
      step_o     = 1'b1;
      len_step_o = !last_i;
      st_d       = last_i ? S_FIN : first_st(mode_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      hbyte_q <= '0;
      xbyte_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_RD_H && h_ack_i) hbyte_q <= h_rdata_i;
      if (st_q == S_RD_X && x_ack_i) xbyte_q <= x_rdata_i;
    end
  end

  assign h_wdata_o = xbyte_q;
  assign x_wdata_o = hbyte_q;
  assign busy_o    = !(st_q == S_IDLE || st_q == S_ARMED);

  a_r2_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(h_req_o && x_req_o));
  a_r6_quiet_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_ARMED) |-> (!h_req_o && !x_req_o));
  a_r5_mismatch_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> (fin_o && !step_o));
endmodule

// File: rtl/rdma_top.sv
module rdma_top import rdma_pkg::*; #(
  parameter int unsigned BANK_W    = 3,
  parameter logic [15:0] TRIG_ADDR = 16'hFF00,
  parameter logic [3:0]  VERSION   = 4'h0,
  parameter logic        CHIP_TYPE = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_cs_i,
  input  logic                 reg_we_i,
  input  logic [3:0]           reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  input  logic                 snoop_we_i,
  input  logic [15:0]          snoop_addr_i,
  output logic                 h_req_o,
  output logic                 h_we_o,
  output logic [15:0]          h_addr_o,
  output logic [7:0]           h_wdata_o,
  input  logic [7:0]           h_rdata_i,
  input  logic                 h_ack_i,
  output logic                 x_req_o,
  output logic                 x_we_o,
  output logic [16+BANK_W-1:0] x_addr_o,
  output logic [7:0]           x_wdata_o,
  input  logic [7:0]           x_rdata_i,
  input  logic                 x_ack_i,
  output logic                 irq_o,
  output logic                 busy_o
);
  localparam int unsigned EXT_W = 16 + BANK_W;

  logic busy, reg_wr, reg_rd, rd_stat;
  logic wr_cmd, wr_h, wr_x, wr_l, wr_ictl, wr_actl;
  logic step, len_step, fin, mismatch, trig, do_reload;
  logic [15:0]      h_cur, h_val, l_cur, l_val;
  logic [EXT_W-1:0] x_cur, x_val;
  logic [7:0]       bank_rd;

  logic       cmd_exec, cmd_reload, cmd_imm;
  xfer_mode_e cmd_mode;
  logic [2:0] ictl_q;
  logic [1:0] actl_q;
  logic       st_irq, st_end, st_err, set_irq;

  assign reg_wr  = reg_cs_i && reg_we_i && !busy;
  assign reg_rd  = reg_cs_i && !reg_we_i;
  assign rd_stat = reg_rd && (reg_addr_i == OFS_STAT);
  assign wr_cmd  = reg_wr && (reg_addr_i == OFS_CMD);
  assign wr_h    = reg_wr && (reg_addr_i == OFS_HLO || reg_addr_i == OFS_HHI);
  assign wr_x    = reg_wr && (reg_addr_i == OFS_XLO || reg_addr_i == OFS_XHI
                              || reg_addr_i == OFS_BANK);
  assign wr_l    = reg_wr && (reg_addr_i == OFS_LLO || reg_addr_i == OFS_LHI);
  assign wr_ictl = reg_wr && (reg_addr_i == OFS_ICTL);
  assign wr_actl = reg_wr && (reg_addr_i == OFS_ACTL);
  assign trig    = snoop_we_i && (snoop_addr_i == TRIG_ADDR);
  assign do_reload = fin && cmd_reload;

  // byte-merged write values
  always_comb begin
    h_val = h_cur;
    l_val = l_cur;
    x_val = x_cur;
    if (reg_addr_i == OFS_HLO) h_val[7:0]  = reg_wdata_i;
    else                       h_val[15:8] = reg_wdata_i;
    if (reg_addr_i == OFS_LLO) l_val[7:0]  = reg_wdata_i;
    else                       l_val[15:8] = reg_wdata_i;
    case (reg_addr_i)
      OFS_XLO: x_val[7:0]       = reg_wdata_i;
      OFS_XHI: x_val[15:8]      = reg_wdata_i;
      default: x_val[EXT_W-1:16] = reg_wdata_i[BANK_W-1:0];
    endcase
  end

  rdma_ctr #(.W(16), .DOWN(1'b0)) u_hctr (
    .clk_i, .rst_ni, .wr_i(wr_h), .wr_val_i(h_val), .reload_i(do_reload),
    .step_i(step && !actl_q[1]), .cur_o(h_cur));

  rdma_ctr #(.W(EXT_W), .DOWN(1'b0)) u_xctr (
    .clk_i, .rst_ni, .wr_i(wr_x), .wr_val_i(x_val), .reload_i(do_reload),
    .step_i(step && !actl_q[0]), .cur_o(x_cur));

  rdma_ctr #(.W(16), .DOWN(1'b1)) u_lctr (
    .clk_i, .rst_ni, .wr_i(wr_l), .wr_val_i(l_val), .reload_i(do_reload),
    .step_i(len_step), .cur_o(l_cur));

  rdma_fsm u_fsm (
    .clk_i, .rst_ni,
    .cmd_wr_i(wr_cmd), .exec_i(reg_wdata_i[7]), .imm_i(reg_wdata_i[4]),
    .start_mode_i(xfer_mode_e'(reg_wdata_i[1:0])), .mode_i(cmd_mode),
    .trig_i(trig), .last_i(l_cur == 16'd1),
    .h_ack_i, .h_rdata_i, .x_ack_i, .x_rdata_i,
    .h_req_o, .h_we_o, .h_wdata_o, .x_req_o, .x_we_o, .x_wdata_o,
    .step_o(step), .len_step_o(len_step), .fin_o(fin),
    .mismatch_o(mismatch), .busy_o(busy));

  assign set_irq = ictl_q[2] && ((fin && ictl_q[1]) || (mismatch && ictl_q[0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_exec   <= 1'b0;
      cmd_reload <= 1'b0;
      cmd_imm    <= 1'b0;
      cmd_mode   <= M_TO_EXP;
      ictl_q     <= '0;
      actl_q     <= '0;
      st_irq     <= 1'b0;
      st_end     <= 1'b0;
      st_err     <= 1'b0;
    end else begin
      if (wr_cmd) begin
        cmd_exec   <= reg_wdata_i[7];
        cmd_reload <= reg_wdata_i[5];
        cmd_imm    <= reg_wdata_i[4];
        cmd_mode   <= xfer_mode_e'(reg_wdata_i[1:0]);
      end else if (fin) begin
        cmd_exec <= 1'b0;
      end
      if (wr_ictl) ictl_q <= reg_wdata_i[7:5];
      if (wr_actl) actl_q <= reg_wdata_i[7:6];
      st_irq <= set_irq  || (st_irq && !rd_stat);
      st_end <= fin      || (st_end && !rd_stat);
      st_err <= mismatch || (st_err && !rd_stat);
    end
  end

  always_comb begin
    bank_rd = '0;
    bank_rd[BANK_W-1:0] = x_cur[EXT_W-1:16];
  end

  always_comb begin
    case (reg_addr_i)
      OFS_STAT: reg_rdata_o = {st_irq, st_end, st_err, CHIP_TYPE, VERSION};
      OFS_CMD:  reg_rdata_o = {cmd_exec, 1'b0, cmd_reload, cmd_imm, 2'b00, cmd_mode};
      OFS_HLO:  reg_rdata_o = h_cur[7:0];
      OFS_HHI:  reg_rdata_o = h_cur[15:8];
      OFS_XLO:  reg_rdata_o = x_cur[7:0];
      OFS_XHI:  reg_rdata_o = x_cur[15:8];
      OFS_BANK: reg_rdata_o = bank_rd;
      OFS_LLO:  reg_rdata_o = l_cur[7:0];
      OFS_LHI:  reg_rdata_o = l_cur[15:8];
      OFS_ICTL: reg_rdata_o = {ictl_q, 5'b0};
      OFS_ACTL: reg_rdata_o = {actl_q, 6'b0};
      default:  reg_rdata_o = 8'hFF;
    endcase
  end

  assign h_addr_o = h_cur;
  assign x_addr_o = x_cur;
  assign irq_o    = st_irq;
  assign busy_o   = busy;

  a_r11_exec_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> !cmd_exec);
  a_r12_irq_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ictl_q[2]);
  a_r13_no_write_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !fin) |=> $stable(ictl_q) && $stable(actl_q));
endmodule

// File: tb/rdma_top_test.sv
`timescale 1ns/1ps
module rdma_top_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_cs = 0, reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic snoop_we = 0;
  logic [15:0] snoop_addr = 0;
  logic h_req, h_we, x_req, x_we, irq, busy;
  logic [15:0] h_addr;
  logic [18:0] x_addr;
  logic [7:0] h_wdata, x_wdata, h_rdata, x_rdata;
  logic [7:0] hmem [0:4095];
  logic [7:0] xmem [0:4095];
  logic fill_h = 0, fill_x = 0;
  logic [11:0] fill_idx = 0;
  logic [7:0] fill_val = 0;
  int checks = 0, errors = 0, rd_cnt = 0;

  always #2.5 clk = ~clk;

  rdma_top uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_cs_i(reg_cs), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .snoop_we_i(snoop_we), .snoop_addr_i(snoop_addr),
    .h_req_o(h_req), .h_we_o(h_we), .h_addr_o(h_addr), .h_wdata_o(h_wdata),
    .h_rdata_i(h_rdata), .h_ack_i(h_req),
    .x_req_o(x_req), .x_we_o(x_we), .x_addr_o(x_addr), .x_wdata_o(x_wdata),
    .x_rdata_i(x_rdata), .x_ack_i(x_req), .irq_o(irq), .busy_o(busy));

  function automatic logic [11:0] xi(input logic [18:0] a);
    return {a[18:16], a[8:0]};
  endfunction
  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 31 + i * 7 + 3) & 255);
  endfunction

  assign h_rdata = hmem[h_addr[11:0]];
  assign x_rdata = xmem[xi(x_addr)];

  always @(posedge clk) begin
    if (h_req && h_we) hmem[h_addr[11:0]] <= h_wdata;
    if (x_req && x_we) xmem[xi(x_addr)] <= x_wdata;
    if (fill_h) hmem[fill_idx] <= fill_val;
    if (fill_x) xmem[fill_idx] <= fill_val;
    if (h_req && !h_we) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic reg_w(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 0; reg_we = 0;
  endtask

  task automatic reg_r(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_cs = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_cs = 0;
  endtask

  task automatic rchk(input string r, input logic [3:0] a, input int exp);
    logic [7:0] d;
    reg_r(a, d);
    chk(r, d, exp);
  endtask

  task automatic poke(input bit to_x, input logic [11:0] idx, input logic [7:0] v);
    @(negedge clk);
    fill_h = !to_x; fill_x = to_x; fill_idx = idx; fill_val = v;
    @(negedge clk);
    fill_h = 0; fill_x = 0;
  endtask

  task automatic setup(input logic [15:0] ha, input logic [18:0] xa,
                       input logic [15:0] len, input logic [7:0] ictl,
                       input logic [7:0] actl);
    reg_w(4'h2, ha[7:0]);  reg_w(4'h3, ha[15:8]);
    reg_w(4'h4, xa[7:0]);  reg_w(4'h5, xa[15:8]); reg_w(4'h6, 8'(xa[18:16]));
    reg_w(4'h7, len[7:0]); reg_w(4'h8, len[15:8]);
    reg_w(4'h9, ictl);     reg_w(4'hA, actl);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic snoop(input logic wr, input logic [15:0] a);
    @(negedge clk);
    snoop_we = wr; snoop_addr = a;
    @(negedge clk);
    snoop_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", irq, 0);
    rchk("R1 status", 4'h0, 8'h10);
    rchk("R1 cmd", 4'h1, 0);
    rchk("R1 host lo", 4'h2, 0);
    rchk("R1 len hi", 4'h8, 0);
    rchk("R1 bank", 4'h6, 0);

    // R2 host to expansion
    for (int i = 0; i < 8; i++) poke(0, 12'(16'h100 + i), pat(1, i));
    setup(16'h0100, 19'h1_0040, 16'd8, 8'h00, 8'h00);
    reg_w(4'h1, 8'h90);
    wait_idle();
    for (int i = 0; i < 8; i++) chk("R2 data", xmem[xi(19'h1_0040 + 19'(i))], pat(1, i));
    rchk("R2 host lo", 4'h2, 8'h08);
    rchk("R2 host hi", 4'h3, 8'h01);
    rchk("R2 ext lo", 4'h4, 8'h48);
    rchk("R2 len lo", 4'h7, 8'h01);
    rchk("R2 len hi", 4'h8, 8'h00);
    chk("R12 no irq when disabled", irq, 0);
    rchk("R11 status end", 4'h0, 8'h50);
    rchk("R11 status cleared", 4'h0, 8'h10);
    rchk("R11 exec cleared", 4'h1, 8'h10);

    // R3 expansion to host, irq on end
    for (int i = 0; i < 6; i++) poke(1, xi(19'h2_0010 + 19'(i)), pat(2, i));
    setup(16'h0200, 19'h2_0010, 16'd6, 8'hC0, 8'h00);
    reg_w(4'h1, 8'h91);
    wait_idle();
    for (int i = 0; i < 6; i++) chk("R3 data", hmem[12'h200 + 12'(i)], pat(2, i));
    @(negedge clk);
    chk("R12 irq on end", irq, 1);
    rchk("R12 status irq", 4'h0, 8'hD0);
    chk("R12 irq cleared by read", irq, 0);

    // R4 swap with R7 reload
    for (int i = 0; i < 5; i++) begin
      poke(0, 12'(16'h300 + i), pat(3, i));
      poke(1, xi(19'h3_0100 + 19'(i)), pat(4, i));
    end
    setup(16'h0300, 19'h3_0100, 16'd5, 8'h00, 8'h00);
    reg_w(4'h1, 8'hB2);
    wait_idle();
    for (int i = 0; i < 5; i++) begin
      chk("R4 host side", hmem[12'h300 + 12'(i)], pat(4, i));
      chk("R4 ext side", xmem[xi(19'h3_0100 + 19'(i))], pat(3, i));
    end
    rchk("R7 host lo", 4'h2, 8'h00);
    rchk("R7 host hi", 4'h3, 8'h03);
    rchk("R7 ext lo", 4'h4, 8'h00);
    rchk("R7 ext hi", 4'h5, 8'h01);
    rchk("R7 len lo", 4'h7, 8'h05);
    rchk("R11 status", 4'h0, 8'h50);

    // R5 compare
    for (int i = 0; i < 4; i++) poke(0, 12'(16'h400 + i), pat(5, i));
    setup(16'h0400, 19'h4_0000, 16'd4, 8'h00, 8'h00);
    reg_w(4'h1, 8'h90);
    wait_idle();
    rchk("R5 setup status", 4'h0, 8'h50);
    setup(16'h0400, 19'h4_0000, 16'd4, 8'hA0, 8'h00);
    reg_w(4'h1, 8'h93);
    wait_idle();
    chk("R5 match no irq", irq, 0);
    rchk("R5 match status", 4'h0, 8'h50);
    rchk("R5 match host lo", 4'h2, 8'h04);
    poke(0, 12'h402, ~pat(5, 2));
    setup(16'h0400, 19'h4_0000, 16'd4, 8'hA0, 8'h00);
    reg_w(4'h1, 8'h93);
    wait_idle();
    @(negedge clk);
    chk("R12 irq on error", irq, 1);
    rchk("R5 mismatch status", 4'h0, 8'hF0);
    rchk("R5 stop host lo", 4'h2, 8'h02);
    rchk("R5 stop ext lo", 4'h4, 8'h02);
    rchk("R5 stop len lo", 4'h7, 8'h02);

    // R6 deferred start
    for (int i = 0; i < 3; i++) begin
      poke(0, 12'(16'h500 + i), pat(6, i));
      poke(1, xi(19'h5_0000 + 19'(i)), 8'hEE);
    end
    setup(16'h0500, 19'h5_0000, 16'd3, 8'h00, 8'h00);
    reg_w(4'h1, 8'h80);
    repeat (10) @(negedge clk);
    chk("R6 armed idle", busy, 0);
    chk("R6 no early write", xmem[xi(19'h5_0000)], 8'hEE);
    snoop(1, 16'hFF01);
    snoop(0, 16'hFF00);
    repeat (5) @(negedge clk);
    chk("R6 wrong snoop ignored", xmem[xi(19'h5_0000)], 8'hEE);
    rchk("R6 still armed", 4'h1, 8'h80);
    snoop(1, 16'hFF00);
    wait_idle();
    for (int i = 0; i < 3; i++) chk("R6 data", xmem[xi(19'h5_0000 + 19'(i))], pat(6, i));
    rchk("R6 status", 4'h0, 8'h50);

    // R8 bank wrap
    reg_w(4'h6, 8'hFF);
    rchk("R8 bank width", 4'h6, 8'h07);
    for (int i = 0; i < 3; i++) poke(0, 12'(16'h600 + i), pat(7, i));
    setup(16'h0600, 19'h7_FFFE, 16'd3, 8'h00, 8'h00);
    reg_w(4'h1, 8'h90);
    wait_idle();
    chk("R8 byte0", xmem[xi(19'h7_FFFE)], pat(7, 0));
    chk("R8 byte1", xmem[xi(19'h7_FFFF)], pat(7, 1));
    chk("R8 byte2 wrapped", xmem[xi(19'h0_0000)], pat(7, 2));
    rchk("R8 ext lo", 4'h4, 8'h01);
    rchk("R8 ext hi", 4'h5, 8'h00);
    rchk("R8 bank wrapped", 4'h6, 8'h00);

    // R9 fixed addresses
    poke(0, 12'h700, 8'hA5);
    setup(16'h0700, 19'h6_0000, 16'd4, 8'h00, 8'h80);
    reg_w(4'h1, 8'h90);
    wait_idle();
    for (int i = 0; i < 4; i++) chk("R9 host fixed data", xmem[xi(19'h6_0000 + 19'(i))], 8'hA5);
    rchk("R9 host held", 4'h2, 8'h00);
    rchk("R9 ext moved", 4'h4, 8'h04);
    poke(1, xi(19'h6_0000), 8'h3C);
    setup(16'h0710, 19'h6_0000, 16'd3, 8'h00, 8'h40);
    reg_w(4'h1, 8'h91);
    wait_idle();
    for (int i = 0; i < 3; i++) chk("R9 ext fixed data", hmem[12'h710 + 12'(i)], 8'h3C);
    rchk("R9 ext held", 4'h4, 8'h00);
    rchk("R9 host moved", 4'h2, 8'h13);

    // R10 length zero, R13 writes ignored while busy
    poke(0, 12'h800, 8'h69);
    setup(16'h0800, 19'h0_0000, 16'd0, 8'h00, 8'hC0);
    base = rd_cnt;
    reg_w(4'h1, 8'h90);
    repeat (100) @(negedge clk);
    reg_w(4'h2, 8'h55);
    reg_w(4'hA, 8'h00);
    wait_idle();
    @(negedge clk);
    chk("R10 byte count", rd_cnt - base, 65536);
    chk("R10 data", xmem[0], 8'h69);
    rchk("R10 len lo", 4'h7, 8'h01);
    rchk("R13 host lo kept", 4'h2, 8'h00);
    rchk("R13 host hi kept", 4'h3, 8'h08);
    rchk("R13 actl kept", 4'hA, 8'hC0);
    finish_run();
  end
endmodule